// File: doc/BRIEF.md
# Sampling Converter Serial Readout Sequencer

This block produces the serial data stream of a 16-bit sampling converter. It runs on a fast system clock and watches two slow external inputs: an active-low select and a data clock from the host. A high-to-low transition of the select opens a read cycle. The block counts the falling edges of the data clock and uses that count to step through the cycle. The first few edges belong to the sampling interval, and during that time the serial line is not driven. Next comes one null bit driven low. The conversion word then goes out most significant bit first. After that the word is repeated least significant bit first. Finally the line is released and stays released until the select has been raised and lowered again.

The converted value arrives on a parallel input and is captured at the edge that ends sampling. The three-state line is modelled as a data bit plus an enable: the line is in high impedance whenever the enable is low. Two status outputs are provided. One says whether the analog section is busy. The other says whether the part is in full shutdown, which is the case while the select is high. The block can be short cycled: raising the select at any point ends the cycle.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset, with the select input held high and the data clock idle, `sdo_en` is 0, `analog_active` is 0 and `full_shutdown` is 1.
- R2: A cycle begins only on a high-to-low transition of `cs_n_in` seen after reset. A select that is already low at reset, with data-clock edges following, leaves `sdo_en` at 0.
- R3: Over the first 4 falling data-clock edges after the select falls, and before the first of them, `sdo_en` is 0.
- R4: After the 5th falling edge, `sdo_en` is 1 and `sdo_data` is 0 for exactly one data-clock period (the null bit).
- R5: After falling edge k, for k = 6 to 21, `sdo_data` carries word bit 21-k, so bit 15 comes first. The word is the value on `conv_word` at the 5th falling edge, and later changes of `conv_word` have no effect on the cycle.
- R6: After falling edge k, for k = 22 to 36, `sdo_data` carries word bit k-21. Bit 0 is sent only once, and the reversed pass runs from bit 1 to bit 15.
- R7: From the 37th falling edge on, `sdo_en` is 0, and further data-clock edges change nothing until the select is raised and lowered again.
- R8: Raising `cs_n_in` at any point in a cycle drives `sdo_en` to 0 within 3 system clocks. The next falling edge of the select starts a complete new cycle.
- R9: `analog_active` is 1 from the select's falling edge up to the 21st falling data-clock edge. From the 22nd falling edge it is 0, even while the select stays low.
- R10: `full_shutdown` follows the synchronized select level and is 1 within 3 system clocks after `cs_n_in` rises.
- R11: The word is sent bit for bit with no recoding, so the two's complement codes 0x7FFF (positive full scale less one step), 0x8000 (negative full scale) and 0x0000 (midscale) appear on the line unchanged.
- R12: `cs_n_in` and `dclk_in` each pass through a two-flop synchronizer. An output reacts to a data-clock falling edge within 3 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the data clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_in | input | 1 | Active-low select, asynchronous to clk |
| dclk_in | input | 1 | Serial data clock from the host, asynchronous to clk |
| conv_word | input | 16 | Conversion result, two's complement |
| sdo_data | output | 1 | Serial data value when driven |
| sdo_en | output | 1 | Serial line driver enable; 0 means high impedance |
| analog_active | output | 1 | Analog section busy with the current conversion |
| full_shutdown | output | 1 | Select high, whole block powered down |

## Verification
The hardest states to reach from the ports are a select raised in the middle of the reversed pass, and the done state with more clocks applied after it. Either one takes a run of more than 30 data-clock edges at a precise count. The stimulus picks random frame lengths from 3 to 45 falling edges, which cover every phase boundary, and ends each frame by raising the select at that count. Directed frames force the exact boundaries at 5, 21, 22, 36 and 37. They also cover the full-scale codes and a change of `conv_word` after it has been captured.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_NULL,
        PH_MSB,
        PH_LSB,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic en;
        logic dat;
    } pin_t;

    // Phase of the read cycle after n falling data-clock edges.
    function automatic phase_t phase_of(logic active, int n, int sample_falls, int word_w);
        int msb_start;
        int lsb_start;
        int last;
        msb_start = sample_falls + 1;
        lsb_start = msb_start + word_w;
        last      = lsb_start + word_w - 1;
        if (!active)              return PH_IDLE;
        else if (n < sample_falls) return PH_SAMPLE;
        else if (n == sample_falls) return PH_NULL;
        else if (n < lsb_start)    return PH_MSB;
        else if (n < last)         return PH_LSB;
        else                       return PH_DONE;
    endfunction

    function automatic int frame_end(int sample_falls, int word_w);
        return sample_falls + 2 * word_w;
    endfunction

endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic fell
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], din};
            prev <= sh[STAGES-1];
        end
    end

    assign level = sh[STAGES-1];
    assign fell  = prev & ~sh[STAGES-1];
endmodule

// File: rtl/sar_seq_frame.sv
module sar_seq_frame #(
    parameter int WORD_W       = 16,
    parameter int SAMPLE_FALLS = 5,
    parameter int CNT_W        = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_hi,
    input  logic             cs_fall,
    input  logic             dclk_fall,
    output logic             active,
    output logic [CNT_W-1:0] cnt
);
    localparam int LAST = sar_seq_pkg::frame_end(SAMPLE_FALLS, WORD_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (cs_hi) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (cs_fall) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && dclk_fall && cnt != CNT_W'(LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: the edge count saturates at the end of the frame
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(LAST));

    // R12: inside a cycle the count only advances by one per step
    p_cnt_step_r12: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

    // R8: a high select closes the cycle on the next clock
    p_cs_closes_r8: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> !active);
endmodule

// File: rtl/sar_seq_shift.sv
module sar_seq_shift #(
    parameter int WORD_W       = 16,
    parameter int SAMPLE_FALLS = 5,
    parameter int CNT_W        = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dclk_fall,
    input  logic [WORD_W-1:0] conv_word,
    output logic              sdo_data,
    output logic              sdo_en,
    output logic              analog_active
);
    import sar_seq_pkg::*;

    localparam int IDX_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int MSB_START = SAMPLE_FALLS + 1;
    localparam int LSB_START = MSB_START + WORD_W;
    localparam int MSB_LAST  = LSB_START - 1;

    logic [WORD_W-1:0] word_q;
    phase_t            ph;
    pin_t              pin;
    int                n;
    int                idx;

    // Capture the result on the edge that closes sampling.
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (active && dclk_fall && cnt == CNT_W'(SAMPLE_FALLS - 1)) begin
            word_q <= conv_word;
        end
    end

    always_comb begin
        n   = int'(cnt);
        ph  = phase_of(active, n, SAMPLE_FALLS, WORD_W);
        idx = 0;
        pin = '{en: 1'b0, dat: 1'b0};
        unique case (ph)
            PH_NULL: pin = '{en: 1'b1, dat: 1'b0};
            PH_MSB: begin
                idx = MSB_LAST - n;
                pin = '{en: 1'b1, dat: word_q[idx[IDX_W-1:0]]};
            end
            PH_LSB: begin
                idx = n - MSB_LAST;
                pin = '{en: 1'b1, dat: word_q[idx[IDX_W-1:0]]};
            end
            default: pin = '{en: 1'b0, dat: 1'b0};
        endcase
    end

    assign sdo_en        = pin.en;
    assign sdo_data      = pin.dat;
    assign analog_active = active && (n < LSB_START);

    // R4: the first bit driven in a cycle is the low null bit
    p_first_null_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en) |-> !sdo_data);

    // R5: the captured word stays fixed while it is being sent
    p_word_held_r5: assert property (@(posedge clk) disable iff (rst)
        ((ph == PH_MSB || ph == PH_LSB) && $past(ph == PH_MSB || ph == PH_LSB))
        |-> $stable(word_q));

    // R9: analog activity has ended by the time the reversed pass runs
    p_analog_off_r9: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LSB || ph == PH_DONE) |-> !analog_active);
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
    parameter int WORD_W       = 16,
    parameter int SAMPLE_FALLS = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_in,
    input  logic              dclk_in,
    input  logic [WORD_W-1:0] conv_word,
    output logic              sdo_data,
    output logic              sdo_en,
    output logic              analog_active,
    output logic              full_shutdown
);
    localparam int LAST  = sar_seq_pkg::frame_end(SAMPLE_FALLS, WORD_W);
    localparam int CNT_W = $clog2(LAST + 1);

    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] fel;
    logic             active;
    logic [CNT_W-1:0] cnt;

    assign raw = {cs_n_in, dclk_in};

    for (genvar i = 0; i < 2; i++) begin : g_sync
        sar_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[i]),
            .level(lvl[i]),
            .fell (fel[i])
        );
    end

    sar_seq_frame #(
        .WORD_W(WORD_W), .SAMPLE_FALLS(SAMPLE_FALLS), .CNT_W(CNT_W)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .cs_hi    (lvl[1]),
        .cs_fall  (fel[1]),
        .dclk_fall(fel[0]),
        .active   (active),
        .cnt      (cnt)
    );

    sar_seq_shift #(
        .WORD_W(WORD_W), .SAMPLE_FALLS(SAMPLE_FALLS), .CNT_W(CNT_W)
    ) u_shift (
        .clk          (clk),
        .rst          (rst),
        .active       (active),
        .cnt          (cnt),
        .dclk_fall    (fel[0]),
        .conv_word    (conv_word),
        .sdo_data     (sdo_data),
        .sdo_en       (sdo_en),
        .analog_active(analog_active)
    );

    assign full_shutdown = lvl[1];

    // R10: shutdown releases the line on the following clock
    p_shutdown_hiz_r10: assert property (@(posedge clk) disable iff (rst)
        full_shutdown |=> !sdo_en);

    // R9: shutdown clears analog activity on the following clock
    p_shutdown_analog_r9: assert property (@(posedge clk) disable iff (rst)
        full_shutdown |=> !analog_active);
endmodule

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n_in;
    logic        dclk_in;
    logic [15:0] conv_word;
    logic        sdo_data, sdo_en, analog_active, full_shutdown;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sar_serial_seq u_dut (
        .clk(clk), .rst(rst), .cs_n_in(cs_n_in), .dclk_in(dclk_in),
        .conv_word(conv_word), .sdo_data(sdo_data), .sdo_en(sdo_en),
        .analog_active(analog_active), .full_shutdown(full_shutdown)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_en(int k);
        return (k >= 5 && k <= 36);
    endfunction

    function automatic logic exp_dat(int k, logic [15:0] w);
        if (k >= 6 && k <= 21)  return w[21-k];
        if (k >= 22 && k <= 36) return w[k-21];
        return 1'b0;
    endfunction

    // Run one cycle with nfalls falling data-clock edges, optional word change after edge 5.
    task automatic frame(logic [15:0] w, int nfalls, bit change_word, string tag);
        conv_word = w;
        dclk_in   = 1'b1;
        cs_n_in   = 1'b0;
        wclk(6);
        chk({tag, " R3 hiz before edges"}, 32'(sdo_en), 0);
        chk({tag, " R9 analog on"}, 32'(analog_active), 1);
        for (int k = 1; k <= nfalls; k++) begin
            dclk_in = 1'b0;
            wclk(6);
            if (k == 5 && change_word) conv_word = ~w;
            chk($sformatf("%s R3/R4/R7 en k=%0d", tag, k), 32'(sdo_en), 32'(exp_en(k)));
            if (exp_en(k))
                chk($sformatf("%s R4/R5/R6 data k=%0d", tag, k), 32'(sdo_data), 32'(exp_dat(k, w)));
            chk($sformatf("%s R9 analog k=%0d", tag, k), 32'(analog_active), 32'(k < 22));
            dclk_in = 1'b1;
            wclk(6);
        end
        cs_n_in = 1'b1;
        wclk(4);
        chk({tag, " R8 hiz after select high"}, 32'(sdo_en), 0);
        chk({tag, " R10 shutdown"}, 32'(full_shutdown), 1);
        wclk(4);
    endtask

    initial begin
        void'($urandom(32'h1bad5eed));
        rst = 1'b1; cs_n_in = 1'b0; dclk_in = 1'b1; conv_word = 16'h0;
        wclk(4);
        rst = 1'b0;
        // R2: select low through reset, clocks must not start a cycle
        for (int k = 0; k < 8; k++) begin
            dclk_in = 1'b0; wclk(6);
            chk("R2 no start without falling select", 32'(sdo_en), 0);
            dclk_in = 1'b1; wclk(6);
        end
        cs_n_in = 1'b1;
        rst = 1'b1; wclk(4); rst = 1'b0; wclk(4);
        chk("R1 reset en", 32'(sdo_en), 0);
        chk("R1 reset analog", 32'(analog_active), 0);
        chk("R1 reset shutdown", 32'(full_shutdown), 1);

        frame(16'hA5C3, 45, 1'b0, "full R7 R12");
        frame(16'h7FFF, 22, 1'b0, "R11 pos full");
        frame(16'h8000, 36, 1'b0, "R11 neg full");
        frame(16'h0000, 37, 1'b0, "R11 mid");
        frame(16'h1234, 30, 1'b1, "R5 latch");
        frame(16'hBEEF, 12, 1'b0, "R8 short");
        frame(16'hBEEF, 40, 1'b0, "R8 restart");
        for (int i = 0; i < 10; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            frame(w, int'($urandom_range(3, 45)), 1'($urandom_range(0, 1)), "rand R5 R6");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule